// File: doc/BRIEF.md
# At-Speed Scan Capture Clock Controller

This block sits between a fast on-chip PLL clock and the clock pins of the scan flops. While scan enable is high it forwards a slow external shift clock to every clock domain output. When a start-of-capture trigger arrives, it emits a short, exactly counted burst of fast pulses gated from the PLL clock. It also drives a registered scan enable whose value can change between two consecutive fast pulses.

A configuration word comes from ordinary scan cells loaded with each pattern. It selects the number of fast pulses, the capture scheme and the clock domains that receive the burst. There are three schemes. Broadside capture issues every fast pulse with scan enable low. Launch-off-shift issues one fast pulse with scan enable high, which is the launch edge, followed by the capture pulses with scan enable low. Burst capture issues several fast shift pulses with scan enable high, the last of which launches, followed by a single capture pulse with scan enable low.

When test mode is low the PLL clock goes straight to every output and the sequencer is held idle. After a burst the controller ignores triggers until scan enable has gone high and then low again.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: While test_mode is 0, every bit of clk_out carries fast_clk unchanged, scan_en_out is 0 and no burst can start.
- R2: While test_mode is 1, the controller is idle and scan_en_in is 1, every bit of clk_out carries shift_clk.
- R3: capture_trig passes through two fast_clk synchroniser stages, then through an edge detector. The first fast pulse rises on the fourth rising fast_clk edge after the trigger is raised.
- R4: capture_cfg[1:0] holds a count code c, and the burst base count is N = c + 1 (00 gives 1 and 11 gives 4).
- R5: Scheme code capture_cfg[3:2] = 00 selects broadside, and code 11 acts the same. Exactly N fast pulses are issued, and scan_en_out is 0 for every one of them.
- R6: Scheme code 01 selects launch-off-shift. N+1 fast pulses are issued; scan_en_out is 1 for the first pulse and 0 for the remaining N.
- R7: Scheme code 10 selects burst. N+1 fast pulses are issued; scan_en_out is 1 for the first N pulses and 0 for the last one.
- R8: Bit capture_cfg[4+i] enables fast pulses on clk_out[i]. A domain whose bit is 0 receives no fast pulse.
- R9: The fast pulses of one burst are back to back, one per fast_clk period, with no missing cycle.
- R10: After a burst, or after reset, a trigger edge starts nothing until scan_en_in has been 1 and then 0 while idle. A trigger raised while scan_en_in is 1 is also ignored.
- R11: While idle in test mode, scan_en_out follows scan_en_in three rising fast_clk edges later. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 selects scan clocking, 0 selects the functional clock |
| shift_clk | input | 1 | Slow external shift clock |
| scan_en_in | input | 1 | Scan enable from the pin |
| capture_trig | input | 1 | Asynchronous start-of-capture trigger |
| capture_cfg | input | CNT_W+2+NUM_DOM | Scan-loaded word: count code, scheme, domain enables |
| clk_out | output | NUM_DOM | Clock for each domain |
| scan_en_out | output | 1 | Retimed scan enable for the scan cells |

## Verification
On every cycle the assertions check these properties: the sequencer stays idle while test mode is low, it never starts without being re-armed, it starts only after the synchronised scan enable has fallen, its pulse index stays within the programmed total, broadside pulses carry a low scan enable, and a launch-off-shift burst opens with scan enable high. Other properties need the bench's sweep over every scheme, count code and domain mask. These are the exact number of edges each output domain sees, the per-pulse scan-enable pattern, the trigger-to-first-pulse latency, the back-to-back spacing and the pass-through behaviour of the shift and functional clocks.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;

    typedef enum logic [1:0] {
        SCH_BROAD = 2'b00,
        SCH_LOS   = 2'b01,
        SCH_BURST = 2'b10,
        SCH_ALT   = 2'b11
    } scheme_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/acc_sync.sv
`timescale 1ns/1ps
module acc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/acc_clk_gate.sv
`timescale 1ns/1ps
module acc_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_l;

    // Enable is captured only while the clock is low, so a pulse is never cut short
    always_latch begin
        if (!clk) begin
            en_l = en;
        end
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/acc_seq.sv
`timescale 1ns/1ps
module acc_seq
    import acc_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int CNT_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       test_mode,
    input  logic                       trig_s,
    input  logic                       se_s,
    input  logic [CNT_W+2+NUM_DOM-1:0] cfg,
    output logic                       pulse_en,
    output logic [NUM_DOM-1:0]         dom_mask,
    output logic                       se_out,
    output logic                       idle
);
    localparam int IDX_W  = CNT_W + 1;
    localparam int SCH_LO = CNT_W;
    localparam int EN_LO  = CNT_W + 2;

    typedef struct packed {
        seq_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   total;
        logic [IDX_W-1:0]   n_base;
        scheme_e            sch;
        logic [NUM_DOM-1:0] mask;
        logic               seen_hi;
        logic               trig_prev;
        logic               pulse_en;
        logic               se;
    } seq_t;

    seq_t q, d;

    function automatic logic se_for(scheme_e s, logic [IDX_W-1:0] p, logic [IDX_W-1:0] n);
        case (s)
            SCH_LOS:   return (p == '0);
            SCH_BURST: return (p < n);
            default:   return 1'b0;
        endcase
    endfunction

    logic             rise;
    scheme_e          start_sch;
    logic [IDX_W-1:0] start_n;
    logic [IDX_W-1:0] start_total;

    always_comb begin
        rise        = trig_s && !q.trig_prev;
        start_sch   = scheme_e'(cfg[SCH_LO+1:SCH_LO]);
        start_n     = IDX_W'(cfg[CNT_W-1:0]) + IDX_W'(1);
        start_total = ((start_sch == SCH_LOS) || (start_sch == SCH_BURST))
                      ? start_n + IDX_W'(1) : start_n;

        d           = q;
        d.trig_prev = trig_s;

        if (!test_mode) begin
            d = '0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    d.pulse_en = 1'b0;
                    d.se       = se_s;
                    if (se_s) begin
                        d.seen_hi = 1'b1;
                    end
                    if (rise && q.seen_hi && !se_s) begin
                        d.st       = ST_RUN;
                        d.sch      = start_sch;
                        d.n_base   = start_n;
                        d.total    = start_total;
                        d.mask     = cfg[EN_LO+NUM_DOM-1:EN_LO];
                        d.seen_hi  = 1'b0;
                        d.pulse_en = 1'b1;
                        d.se       = se_for(start_sch, '0, start_n);
                        d.idx      = IDX_W'(1);
                    end
                end
                default: begin
                    if (q.idx == q.total) begin
                        d.st       = ST_IDLE;
                        d.pulse_en = 1'b0;
                        d.se       = se_s;
                        d.idx      = '0;
                    end else begin
                        d.pulse_en = 1'b1;
                        d.se       = se_for(q.sch, q.idx, q.n_base);
                        d.idx      = q.idx + IDX_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_en = q.pulse_en;
    assign dom_mask = q.mask;
    assign se_out   = q.se;
    assign idle     = (q.st == ST_IDLE);

    // R1: functional mode keeps the sequencer quiet
    a_r1_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (q.st == ST_IDLE && !q.pulse_en));

    // R10: an unarmed idle sequencer cannot start on the next edge
    a_r10_need_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !q.seen_hi) |=> (q.st == ST_IDLE));

    // R10: a burst only starts once the synchronised scan enable is low
    a_r10_start_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && $past(q.st) == ST_IDLE) |-> !$past(se_s));

    // R9: pulse index stays inside the programmed total
    a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> (q.idx != '0 && q.idx <= q.total));

    // R5: broadside pulses always see scan enable low
    a_r5_broadside_se_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pulse_en && q.sch != SCH_LOS && q.sch != SCH_BURST) |-> !q.se);

    // R6: launch-off-shift opens with a shifting launch pulse
    a_r6_los_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && $past(q.st) == ST_IDLE && q.sch == SCH_LOS) |-> q.se);
endmodule

// File: rtl/atspeed_clk_ctrl.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl #(
    parameter int NUM_DOM     = 2,
    parameter int CNT_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       fast_clk,
    input  logic                       rst_n,
    input  logic                       test_mode,
    input  logic                       shift_clk,
    input  logic                       scan_en_in,
    input  logic                       capture_trig,
    input  logic [CNT_W+2+NUM_DOM-1:0] capture_cfg,
    output logic [NUM_DOM-1:0]         clk_out,
    output logic                       scan_en_out
);
    logic [1:0]         sync_out;
    logic               trig_s;
    logic               se_s;
    logic               pulse_en;
    logic [NUM_DOM-1:0] dom_mask;
    logic               se_q;
    logic               idle;
    logic               shift_sel;
    logic [NUM_DOM-1:0] gclk;

    acc_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (fast_clk),
        .rst_n (rst_n),
        .din   ({capture_trig, scan_en_in}),
        .dout  (sync_out)
    );

    assign trig_s = sync_out[1];
    assign se_s   = sync_out[0];

    acc_seq #(
        .NUM_DOM (NUM_DOM),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (fast_clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .trig_s    (trig_s),
        .se_s      (se_s),
        .cfg       (capture_cfg),
        .pulse_en  (pulse_en),
        .dom_mask  (dom_mask),
        .se_out    (se_q),
        .idle      (idle)
    );

    assign shift_sel = idle & scan_en_in;

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        acc_clk_gate u_gate (
            .clk  (fast_clk),
            .en   (pulse_en & dom_mask[i]),
            .gclk (gclk[i])
        );
        assign clk_out[i] = !test_mode ? fast_clk
                          : (shift_sel ? shift_clk : gclk[i]);
    end

    assign scan_en_out = test_mode & se_q;
endmodule

// File: tb/atspeed_clk_ctrl_bench.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl_bench;
    logic       fast_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b1;
    logic       shift_clk = 1'b0;
    logic       se_in = 1'b0;
    logic       trig = 1'b0;
    logic [5:0] cfg = '0;
    wire  [1:0] clk_out;
    wire        se_out;
    wire        c0 = clk_out[0];
    wire        c1 = clk_out[1];

    atspeed_clk_ctrl u_atspeed_clk_ctrl (
        .fast_clk     (fast_clk),
        .rst_n        (rst_n),
        .test_mode    (test_mode),
        .shift_clk    (shift_clk),
        .scan_en_in   (se_in),
        .capture_trig (trig),
        .capture_cfg  (cfg),
        .clk_out      (clk_out),
        .scan_en_out  (se_out)
    );

    always #5 fast_clk = ~fast_clk;

    int cyc = 0;
    always @(negedge fast_clk) cyc++;

    logic se_last = 1'b0;
    always @(negedge fast_clk) se_last <= se_out;

    int cnt0 = 0, cnt1 = 0;
    always @(posedge c0) cnt0++;
    always @(posedge c1) cnt1++;

    logic       rec_on = 1'b0;
    int         rec = 0, first_cyc = 0, last_cyc = 0;
    logic [7:0] se_bits = '0;
    always @(posedge fast_clk) begin
        #1;
        if (rec_on && clk_out != 2'b00) begin
            if (rec < 8) se_bits[rec] = se_last;
            if (rec == 0) first_cyc = cyc;
            last_cyc = cyc;
            rec++;
        end
    end

    int total = 0, fails = 0;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        cnt0 = 0; cnt1 = 0; rec = 0; se_bits = '0;
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge fast_clk);
    endtask

    task automatic shift_pulse();
        @(negedge fast_clk); shift_clk = 1'b1;
        @(negedge fast_clk); shift_clk = 1'b0;
    endtask

    task automatic run_case(int sch, int code, int en);
        int t0, n, tot, exp_se, tag_se;
        string rs;
        cfg = {en[1:0], sch[1:0], code[1:0]};
        se_in = 1'b1; wait_neg(4);
        shift_pulse();
        se_in = 1'b0; wait_neg(4);
        clear_counts();
        rec_on = 1'b1;
        @(negedge fast_clk); #1;
        trig = 1'b1; t0 = cyc;
        wait_neg(14);
        rec_on = 1'b0;
        trig = 1'b0;
        wait_neg(3);
        n = code + 1;
        tot = (sch == 1 || sch == 2) ? n + 1 : n;
        exp_se = 0;
        for (int p = 0; p < tot; p++) begin
            if ((sch == 1 && p == 0) || (sch == 2 && p < n)) exp_se |= (1 << p);
        end
        rs = (sch == 1) ? "R6" : ((sch == 2) ? "R7" : "R5");
        chk({"R4 ", rs, " pulses dom0"}, cnt0, en[0] ? tot : 0);
        chk({"R8 ", rs, " pulses dom1"}, cnt1, en[1] ? tot : 0);
        if (en != 0) begin
            tag_se = int'(se_bits) & ((1 << tot) - 1);
            chk({rs, " scan enable per pulse"}, tag_se, exp_se);
            chk("R3 trigger to first pulse", first_cyc - t0, 3);
            chk("R9 back to back span", last_cyc - first_cyc, tot - 1);
            chk("R9 recorded pulses", rec, tot);
        end
    endtask

    initial begin
        #1_000_000;
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        wait_neg(3);
        @(posedge fast_clk); #1;
        chk("R11 reset clk_out", int'(clk_out), 0);
        chk("R11 reset scan_en_out", int'(se_out), 0);
        @(negedge fast_clk); rst_n = 1'b1;
        wait_neg(2);

        // R1: functional pass-through
        test_mode = 1'b0; se_in = 1'b1; trig = 1'b1;
        wait_neg(2);
        clear_counts();
        wait_neg(10);
        chk("R1 dom0 follows fast_clk", cnt0, 10);
        chk("R1 dom1 follows fast_clk", cnt1, 10);
        chk("R1 scan_en_out low", int'(se_out), 0);
        @(negedge fast_clk); test_mode = 1'b1; se_in = 1'b0; trig = 1'b0;
        wait_neg(5);

        // R11: idle scan enable retiming
        @(negedge fast_clk); se_in = 1'b1;
        wait_neg(2);
        chk("R11 scan_en_out before third edge", int'(se_out), 0);
        wait_neg(1);
        chk("R11 scan_en_out after third edge", int'(se_out), 1);

        // R2: shift clock pass-through
        clear_counts();
        for (int k = 0; k < 3; k++) shift_pulse();
        chk("R2 dom0 shift edges", cnt0, 3);
        chk("R2 dom1 shift edges", cnt1, 3);
        se_in = 1'b0; wait_neg(4);

        // R4..R9: sweep of scheme, count and domain mask
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 4; c++)
                for (int e = 0; e < 4; e++)
                    run_case(s, c, e);

        // R10: re-arming
        cfg = 6'b110001;
        clear_counts();
        @(negedge fast_clk); trig = 1'b1;
        wait_neg(10);
        chk("R10 no rearm dom0", cnt0, 0);
        trig = 1'b0; wait_neg(3);
        se_in = 1'b1; wait_neg(4);
        clear_counts();
        trig = 1'b1; wait_neg(8);
        se_in = 1'b0; wait_neg(8);
        chk("R10 trigger during shift ignored", cnt0 + cnt1, 0);
        trig = 1'b0; wait_neg(4);
        clear_counts();
        trig = 1'b1; wait_neg(10);
        chk("R10 rearmed burst dom0", cnt0, 2);
        chk("R10 rearmed burst dom1", cnt1, 2);
        trig = 1'b0; wait_neg(3);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule